// File: doc/BRIEF.md
# Spare-Area Error-Count Field Codec and BER Level Selector

This block keeps a small per-codeword record of how many bit errors were still left after a page was rewritten in place. On the write side it takes an uncorrected-error count and turns it into a field value. Because a flash bit can only move from 1 to 0 without an erase, the field holds a thermometer of cleared bits, with one cleared bit for every two errors. It also produces single-error-correcting, double-error-detecting check bits so the field can sit in spare area next to the codeword. The field and its check bits are rewritten together with the codeword.

On the read side the block takes the stored field and check bits. It repairs a single flipped bit and counts the cleared bits in the repaired field. It then returns that count as an index into a decoder input-BER table, so a larger index means a higher assumed error probability. An all-ones field means no count has been recorded yet, as on a codeword's first decode, and it selects the default index. An uncorrectable field also selects the default index and raises a flag. Each path registers its result one cycle after its strobe. The two paths are independent and may be strobed in the same cycle.

Top module: `errfld_ber_sel`

## Requirements
- R1: One cycle after `wr_strobe`, `wr_valid` is 1. `wr_field` then has its lowest ceil(count/ERR_PER_BIT) bits (bit 0 first) at 0 and the rest at 1. A count of 0 gives all ones.
- R2: A count whose cleared-bit total would exceed FIELD_W clears all FIELD_W bits, so `wr_field` is all zeros.
- R3: `wr_check` is an extended Hamming code. Data bit j occupies the j-th codeword position (counting from 1) that is not a power of two, starting at position 3. Check bit i (i < P) is the XOR of the data bits whose position has bit i set. Check bit P is the XOR of all data bits and check bits 0..P-1.
- R4: One cycle after `rd_strobe`, `rd_valid` is 1 and `rd_level` equals the number of 0 bits in the corrected field, which may sit in any positions. With defaults this is 1 to 8.
- R5: A corrected field of all ones sets `rd_no_info` to 1 and `rd_level` to DEFAULT_LVL (0 by default).
- R6: A single flipped bit anywhere in the field or check bits is corrected before counting, and `rd_fixed` is 1. A clean read gives `rd_fixed` 0.
- R7: Two flipped bits set `rd_dbl_err` to 1, `rd_level` to DEFAULT_LVL, and `rd_no_info` and `rd_fixed` to 0.
- R8: Each valid output is high for exactly one cycle per strobe. Between strobes every data output holds its last value.
- R9: While `rst_n` is low, both valids and all flags are 0, `rd_level` is 0, `wr_field` is all ones and `wr_check` is 0.
- R10: A write and a read strobed in the same cycle both produce their correct results in the same following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_strobe | input | 1 | Encode request |
| wr_err_count | input | CNT_W | Uncorrected-error count to record |
| wr_valid | output | 1 | Encoded field ready |
| wr_field | output | FIELD_W | Thermometer field value to program |
| wr_check | output | CHK_W | SEC-DED check bits for the field |
| rd_strobe | input | 1 | Interpret request |
| rd_field | input | FIELD_W | Field as read from spare area |
| rd_check | input | CHK_W | Check bits as read |
| rd_valid | output | 1 | Level result ready |
| rd_level | output | LVL_W | BER table index |
| rd_no_info | output | 1 | No count recorded yet |
| rd_dbl_err | output | 1 | Uncorrectable field |
| rd_fixed | output | 1 | A single bit was corrected |

## Verification
The encode path and the interpret path share the output register stage and can both complete in the same cycle. The bench provokes this by strobing a write and a read together, with a corrupted field on the read side so that correction and counting happen in the same cycle as the encode. A scoreboard holds one expected-item queue per path, and each queue is filled from a model that does not share logic with the design. The read model finds single-bit errors by a brute-force search over every bit flip. Each result must match its own queue in exactly that cycle, and a valid pulse with no pending item, or an item left in a queue at the end, counts as a failure.

// File: rtl/errfld_pkg.sv
`timescale 1ns/1ps
package errfld_pkg;

    // Smallest Hamming parity count p with 2^p >= k + p + 1.
    function automatic int par_bits(input int k);
        int p;
        p = 0;
        for (int t = 1; t < 16; t++) begin
            if (p == 0 && (1 << t) >= k + t + 1) p = t;
        end
        return p;
    endfunction

    // Codeword position of data bit j: j-th non-power-of-two index from 3.
    function automatic int data_pos(input int j);
        int cnt;
        int pos;
        cnt = 0;
        pos = 0;
        for (int q = 3; q < 256; q++) begin
            if (((q & (q - 1)) != 0) && pos == 0) begin
                if (cnt == j) pos = q;
                cnt++;
            end
        end
        return pos;
    endfunction

endpackage

// File: rtl/errfld_therm_enc.sv
`timescale 1ns/1ps
module errfld_therm_enc #(
    parameter int FIELD_W     = 8,
    parameter int ERR_PER_BIT = 2,
    parameter int CNT_W       = 8
) (
    input  logic [CNT_W-1:0]   count_i,
    output logic [FIELD_W-1:0] field_o
);
    int cleared;

    always_comb begin
        cleared = (int'(count_i) + ERR_PER_BIT - 1) / ERR_PER_BIT;
        if (cleared > FIELD_W) cleared = FIELD_W;
        for (int j = 0; j < FIELD_W; j++) begin
            field_o[j] = (j >= cleared);
        end
    end
endmodule

// File: rtl/errfld_secded_enc.sv
`timescale 1ns/1ps
module errfld_secded_enc #(
    parameter int FIELD_W = 8,
    localparam int P      = errfld_pkg::par_bits(FIELD_W),
    localparam int CHK_W  = P + 1
) (
    input  logic [FIELD_W-1:0] data_i,
    output logic [CHK_W-1:0]   check_o
);
    logic [P-1:0] ham;

    always_comb begin
        ham = '0;
        for (int i = 0; i < P; i++) begin
            for (int j = 0; j < FIELD_W; j++) begin
                if (((errfld_pkg::data_pos(j) >> i) & 1) == 1) ham[i] = ham[i] ^ data_i[j];
            end
        end
        check_o = {^{data_i, ham}, ham};
    end
endmodule

// File: rtl/errfld_secded_dec.sv
`timescale 1ns/1ps
module errfld_secded_dec #(
    parameter int FIELD_W = 8,
    localparam int P      = errfld_pkg::par_bits(FIELD_W),
    localparam int CHK_W  = P + 1,
    localparam int N      = FIELD_W + P
) (
    input  logic [FIELD_W-1:0] data_i,
    input  logic [CHK_W-1:0]   check_i,
    output logic [FIELD_W-1:0] data_o,
    output logic               fixed_o,
    output logic               dbl_o
);
    logic [CHK_W-1:0] recalc;
    logic [P-1:0]     syn;
    logic             odd;

    errfld_secded_enc #(.FIELD_W(FIELD_W)) enc_i (
        .data_i  (data_i),
        .check_o (recalc)
    );

    always_comb begin
        syn     = recalc[P-1:0] ^ check_i[P-1:0];
        // Parity over the whole received codeword.
        odd     = recalc[P] ^ (^syn) ^ check_i[P];
        fixed_o = odd && (int'(syn) <= N);
        dbl_o   = (!odd && syn != '0) || (odd && int'(syn) > N);
        for (int j = 0; j < FIELD_W; j++) begin
            data_o[j] = data_i[j] ^ (odd && int'(syn) == errfld_pkg::data_pos(j));
        end
    end
endmodule

// File: rtl/errfld_level.sv
`timescale 1ns/1ps
module errfld_level #(
    parameter int FIELD_W     = 8,
    parameter int DEFAULT_LVL = 0,
    localparam int LVL_W      = $clog2(FIELD_W + 1)
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic               bad_i,
    output logic [LVL_W-1:0]   level_o,
    output logic               no_info_o
);
    int zeros;

    always_comb begin
        zeros = 0;
        for (int j = 0; j < FIELD_W; j++) begin
            if (!field_i[j]) zeros++;
        end
        no_info_o = (zeros == 0) && !bad_i;
        if (bad_i || zeros == 0) level_o = LVL_W'(DEFAULT_LVL);
        else                     level_o = LVL_W'(zeros);
    end
endmodule

// File: rtl/errfld_ber_sel.sv
`timescale 1ns/1ps
module errfld_ber_sel #(
    parameter int FIELD_W     = 8,
    parameter int ERR_PER_BIT = 2,
    parameter int CNT_W       = 8,
    parameter int DEFAULT_LVL = 0,
    localparam int CHK_W      = errfld_pkg::par_bits(FIELD_W) + 1,
    localparam int LVL_W      = $clog2(FIELD_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_strobe,
    input  logic [CNT_W-1:0]   wr_err_count,
    output logic               wr_valid,
    output logic [FIELD_W-1:0] wr_field,
    output logic [CHK_W-1:0]   wr_check,
    input  logic               rd_strobe,
    input  logic [FIELD_W-1:0] rd_field,
    input  logic [CHK_W-1:0]   rd_check,
    output logic               rd_valid,
    output logic [LVL_W-1:0]   rd_level,
    output logic               rd_no_info,
    output logic               rd_dbl_err,
    output logic               rd_fixed
);
    typedef struct packed {
        logic               wr_valid;
        logic [FIELD_W-1:0] wr_field;
        logic [CHK_W-1:0]   wr_check;
        logic               rd_valid;
        logic [LVL_W-1:0]   rd_level;
        logic               rd_no_info;
        logic               rd_dbl;
        logic               rd_fixed;
    } st_t;

    st_t st_d, st_q;

    logic [FIELD_W-1:0] enc_field;
    logic [CHK_W-1:0]   enc_check;
    logic [FIELD_W-1:0] fixed_field;
    logic               dec_fixed, dec_dbl;
    logic [LVL_W-1:0]   lvl;
    logic               lvl_no_info;

    errfld_therm_enc #(.FIELD_W(FIELD_W), .ERR_PER_BIT(ERR_PER_BIT), .CNT_W(CNT_W)) therm_i (
        .count_i (wr_err_count),
        .field_o (enc_field)
    );

    errfld_secded_enc #(.FIELD_W(FIELD_W)) wenc_i (
        .data_i  (enc_field),
        .check_o (enc_check)
    );

    errfld_secded_dec #(.FIELD_W(FIELD_W)) dec_i (
        .data_i  (rd_field),
        .check_i (rd_check),
        .data_o  (fixed_field),
        .fixed_o (dec_fixed),
        .dbl_o   (dec_dbl)
    );

    errfld_level #(.FIELD_W(FIELD_W), .DEFAULT_LVL(DEFAULT_LVL)) lvl_i (
        .field_i   (fixed_field),
        .bad_i     (dec_dbl),
        .level_o   (lvl),
        .no_info_o (lvl_no_info)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wr_valid = wr_strobe;
        st_d.rd_valid = rd_strobe;
        if (wr_strobe) begin
            st_d.wr_field = enc_field;
            st_d.wr_check = enc_check;
        end
        if (rd_strobe) begin
            st_d.rd_level   = lvl;
            st_d.rd_no_info = lvl_no_info;
            st_d.rd_dbl     = dec_dbl;
            st_d.rd_fixed   = dec_fixed && !dec_dbl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wr_valid   <= 1'b0;
            st_q.wr_field   <= '1;
            st_q.wr_check   <= '0;
            st_q.rd_valid   <= 1'b0;
            st_q.rd_level   <= '0;
            st_q.rd_no_info <= 1'b0;
            st_q.rd_dbl     <= 1'b0;
            st_q.rd_fixed   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid   = st_q.wr_valid;
    assign wr_field   = st_q.wr_field;
    assign wr_check   = st_q.wr_check;
    assign rd_valid   = st_q.rd_valid;
    assign rd_level   = st_q.rd_level;
    assign rd_no_info = st_q.rd_no_info;
    assign rd_dbl_err = st_q.rd_dbl;
    assign rd_fixed   = st_q.rd_fixed;

    a_r1_zero_count_erased: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe && wr_err_count == '0 |=> wr_field == '1);
    a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe && int'(wr_err_count) >= ERR_PER_BIT * FIELD_W |=> wr_field == '0);
    a_r3_even_codeword: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (^{wr_field, wr_check}) == 1'b0);
    a_r4_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_no_info && !rd_dbl_err |-> rd_level >= 1 && int'(rd_level) <= FIELD_W);
    a_r5_no_info_default: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_no_info |-> int'(rd_level) == DEFAULT_LVL && !rd_dbl_err);
    a_r7_dbl_default: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_dbl_err |-> int'(rd_level) == DEFAULT_LVL && !rd_no_info && !rd_fixed);
    a_r8_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_valid);
    a_r8_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> !rd_valid && $stable(rd_level));
    a_r8_wr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe |=> !wr_valid && $stable(wr_field) && $stable(wr_check));
    a_r10_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> wr_valid);
endmodule

// File: tb/errfld_ber_sel_tb_top.sv
`timescale 1ns/1ps
module errfld_ber_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_err_count = '0;
    logic       wr_valid;
    logic [7:0] wr_field;
    logic [4:0] wr_check;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_field = '1;
    logic [4:0] rd_check = '0;
    logic       rd_valid;
    logic [3:0] rd_level;
    logic       rd_no_info, rd_dbl_err, rd_fixed;

    int checks = 0;
    int errors = 0;

    logic [12:0] wr_q[$];
    string       wr_tag_q[$];
    logic [6:0]  rd_q[$];
    string       rd_tag_q[$];

    always #10 clk = ~clk;

    errfld_ber_sel dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_strobe(wr_strobe), .wr_err_count(wr_err_count),
        .wr_valid(wr_valid), .wr_field(wr_field), .wr_check(wr_check),
        .rd_strobe(rd_strobe), .rd_field(rd_field), .rd_check(rd_check),
        .rd_valid(rd_valid), .rd_level(rd_level), .rd_no_info(rd_no_info),
        .rd_dbl_err(rd_dbl_err), .rd_fixed(rd_fixed)
    );

    function automatic logic [4:0] tb_enc(input logic [7:0] d);
        logic [3:0] h;
        int pos[8];
        int n;
        n = 0;
        for (int q = 1; q <= 12; q++) begin
            if (q != 1 && q != 2 && q != 4 && q != 8) begin
                pos[n] = q;
                n++;
            end
        end
        h = '0;
        for (int j = 0; j < 8; j++) begin
            for (int i = 0; i < 4; i++) begin
                if (pos[j][i]) h[i] = h[i] ^ d[j];
            end
        end
        return {(^d) ^ (^h), h};
    endfunction

    // Expected read item {level, no_info, dbl, fixed} by brute-force flip search.
    function automatic logic [6:0] tb_read(input logic [7:0] f, input logic [4:0] c);
        logic [7:0] fd;
        logic       fx, db;
        int         hits, zeros;
        fd = f; fx = 1'b0; db = 1'b0;
        if (tb_enc(f) != c) begin
            hits = 0;
            for (int j = 0; j < 8; j++) begin
                if (tb_enc(f ^ (8'd1 << j)) == c) begin
                    hits++;
                    fd = f ^ (8'd1 << j);
                end
            end
            for (int k = 0; k < 5; k++) begin
                if (tb_enc(f) == (c ^ (5'd1 << k))) hits++;
            end
            if (hits == 1) fx = 1'b1;
            else begin db = 1'b1; fd = f; end
        end
        zeros = 8 - $countones(fd);
        if (db)              return {4'd0, 1'b0, 1'b1, 1'b0};
        else if (zeros == 0) return {4'd0, 1'b1, 1'b0, fx};
        else                 return {4'(zeros), 1'b0, 1'b0, fx};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input bit do_wr, input int cnt, input bit do_rd,
                      input logic [7:0] f, input logic [4:0] c, input string tag);
        logic [7:0] ef;
        int n;
        @(negedge clk);
        if (do_wr) begin
            n = (cnt + 1) / 2;
            if (n > 8) n = 8;
            ef = 8'hFF << n;
            wr_q.push_back({ef, tb_enc(ef)});
            wr_tag_q.push_back(tag);
            wr_err_count = 8'(cnt);
            wr_strobe = 1'b1;
        end
        if (do_rd) begin
            rd_q.push_back(tb_read(f, c));
            rd_tag_q.push_back(tag);
            rd_field = f;
            rd_check = c;
            rd_strobe = 1'b1;
        end
        @(negedge clk);
        wr_strobe = 1'b0;
        rd_strobe = 1'b0;
    endtask

    // Monitor: pops the scoreboard when a result appears.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (wr_valid) begin
                    if (wr_q.size() == 0) check(1'b0, "R8 spurious wr_valid", 1, 0);
                    else begin
                        logic [12:0] e;
                        string t;
                        e = wr_q.pop_front();
                        t = wr_tag_q.pop_front();
                        check({wr_field, wr_check} == e, t, {wr_field, wr_check}, e);
                    end
                end
                if (rd_valid) begin
                    if (rd_q.size() == 0) check(1'b0, "R8 spurious rd_valid", 1, 0);
                    else begin
                        logic [6:0] e;
                        string t;
                        e = rd_q.pop_front();
                        t = rd_tag_q.pop_front();
                        check({rd_level, rd_no_info, rd_dbl_err, rd_fixed} == e, t,
                              {rd_level, rd_no_info, rd_dbl_err, rd_fixed}, e);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!wr_valid && !rd_valid, "R9 valids in reset", {wr_valid, rd_valid}, 0);
        check(wr_field == 8'hFF && wr_check == '0, "R9 write outputs in reset", {wr_field, wr_check}, 13'h1FE0);
        check(rd_level == '0 && !rd_no_info && !rd_dbl_err && !rd_fixed, "R9 read outputs in reset",
              {rd_level, rd_no_info, rd_dbl_err, rd_fixed}, 0);
        rst_n = 1'b1;

        // R1 R3 thermometer encode with check bits
        op(1, 0,  0, 8'h00, 5'h0, "R1 R3 count 0");
        op(1, 1,  0, 8'h00, 5'h0, "R1 R3 count 1");
        op(1, 2,  0, 8'h00, 5'h0, "R1 R3 count 2");
        op(1, 3,  0, 8'h00, 5'h0, "R1 R3 count 3");
        op(1, 4,  0, 8'h00, 5'h0, "R1 R3 count 4");
        op(1, 7,  0, 8'h00, 5'h0, "R1 R3 count 7");
        op(1, 15, 0, 8'h00, 5'h0, "R1 R2 count 15");
        op(1, 16, 0, 8'h00, 5'h0, "R2 count 16");
        op(1, 17, 0, 8'h00, 5'h0, "R2 count 17");
        op(1, 200,0, 8'h00, 5'h0, "R2 count 200");
        op(1, 255,0, 8'h00, 5'h0, "R2 count 255");

        // R4 R5 clean reads
        op(0, 0, 1, 8'hFF, tb_enc(8'hFF), "R5 erased field");
        op(0, 0, 1, 8'hFC, tb_enc(8'hFC), "R4 level 2");
        op(0, 0, 1, 8'hF0, tb_enc(8'hF0), "R4 level 4");
        op(0, 0, 1, 8'h00, tb_enc(8'h00), "R4 level 8");
        op(0, 0, 1, 8'h5A, tb_enc(8'h5A), "R4 scattered zeros");
        op(0, 0, 1, 8'hFE, tb_enc(8'hFE), "R4 level 1");

        // R6 single-bit errors
        op(0, 0, 1, 8'hFC ^ 8'h20, tb_enc(8'hFC), "R6 data bit 5 flipped");
        op(0, 0, 1, 8'hF0 ^ 8'h01, tb_enc(8'hF0), "R6 data bit 0 flipped");
        op(0, 0, 1, 8'hC0, tb_enc(8'hC0) ^ 5'h01, "R6 check bit 0 flipped");
        op(0, 0, 1, 8'hC0, tb_enc(8'hC0) ^ 5'h08, "R6 check bit 3 flipped");
        op(0, 0, 1, 8'hE0, tb_enc(8'hE0) ^ 5'h10, "R6 overall bit flipped");
        op(0, 0, 1, 8'hFF ^ 8'h80, tb_enc(8'hFF), "R5 R6 erased field with flip");

        // R7 double-bit errors
        op(0, 0, 1, 8'hF0 ^ 8'h03, tb_enc(8'hF0), "R7 two data bits");
        op(0, 0, 1, 8'hFC ^ 8'h40, tb_enc(8'hFC) ^ 5'h02, "R7 data and check bit");
        op(0, 0, 1, 8'hFF, tb_enc(8'hFF) ^ 5'h11, "R7 two check bits");

        // R10 write and read in the same cycle
        op(1, 5, 1, 8'hF8 ^ 8'h10, tb_enc(8'hF8), "R10 write with corrected read");
        op(1, 16, 1, 8'hF8 ^ 8'h18, tb_enc(8'hF8), "R10 write with double-error read");
        op(1, 0, 1, 8'h00, tb_enc(8'h00), "R10 erased write with level 8 read");

        // R8 outputs hold between strobes
        op(1, 9, 1, 8'hE0, tb_enc(8'hE0), "R8 setup");
        repeat (3) begin
            @(negedge clk);
            check(!rd_valid && !wr_valid, "R8 valids low when idle", {rd_valid, wr_valid}, 0);
            check(rd_level == 4'd5, "R8 level held", rd_level, 5);
            check(wr_field == 8'hE0, "R8 field held", wr_field, 8'hE0);
        end

        repeat (3) @(negedge clk);
        check(wr_q.size() == 0, "R8 write results all delivered", wr_q.size(), 0);
        check(rd_q.size() == 0, "R8 read results all delivered", rd_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule